// File: doc/BRIEF.md
# Address-Mapped NAND Flash Bridge

This block joins one chip-select window of a simple memory bus to a raw NAND flash device that has no protocol engine in front of it. Software runs the whole NAND command flow itself: it writes command bytes, address bytes and data by touching particular offsets in the window, and it reads data back from the data offset. Two low address bits choose the kind of cycle. The bridge turns them into the flash command-latch and address-latch lines. It gates the read and write strobes with the chip-select so that they stay quiet whenever the window is not selected.

A small control register sets several options. It chooses whether the flash enable follows the bus chip-select or a software-held bit. The software-held bit is for parts that need the enable kept asserted through the array-read busy time. The register also drives the write-protect pin and selects an 8-bit or 16-bit data lane. The ready/busy pin passes through a synchronizer. Its rising edge sets a sticky completion interrupt. An access to the unused offset is not sent to the flash. It sets a sticky error flag instead. Both flags are cleared by writing ones to the control register.

Top module: `nand_bus_bridge`

## Requirements
- R1: With the window selected, address bits {a2,a1} = 01 (byte offset 0x2) raise the command-latch output and {a2,a1} = 10 (offset 0x4) raise the address-latch output. Both latch outputs are low for 00, for 11 and while the window is not selected.
- R2: The active-low flash write strobe and the data-output enable are asserted only while the window is selected, the bus write strobe is high and {a2,a1} is not 11.
- R3: The active-low flash read strobe is asserted only for a selected bus read at offset 0x0. A bus read at offset 0x2, 0x4 or 0x6 returns zero and gives no read strobe. Read data is zero whenever the read strobe is inactive.
- R4: The active-low flash enable follows the bus chip-select when control bit 0 (hold mode) is 0. When hold mode is 1, the enable is asserted exactly while control bit 1 (software enable) is 1, whatever the chip-select does.
- R5: The active-low write-protect output is asserted exactly while control bit 2 is 1.
- R6: Control bit 3 selects a 16-bit lane when 1 and an 8-bit lane when 0. In 8-bit mode the upper byte of the flash output data and of the bus read data is zero.
- R7: A rising edge on the ready/busy pin sets the interrupt flag on the third clock edge after the pin rises. The flag stays set until cleared. A falling edge never sets it.
- R8: A control write with bit 4 set clears the interrupt flag. If a rising edge is detected in the same cycle, the flag is set.
- R9: A selected read or write at offset 0x6 sets a sticky error flag on the next clock edge. A control write with bit 5 set clears it.
- R10: After reset the control bits, the interrupt flag and the error flag are zero. The control read value is {error, interrupt, bit3, bit2, bit1, bit0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Window chip-select, active high |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Address bits a2,a1 |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Bus read data |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write value (bits 4,5 clear flags) |
| ctl_rdata | output | 6 | Control and flag read value |
| fl_ce_n | output | 1 | Flash enable, active low |
| fl_cle | output | 1 | Command-latch enable |
| fl_ale | output | 1 | Address-latch enable |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_re_n | output | 1 | Flash read strobe, active low |
| fl_wp_n | output | 1 | Write-protect, active low |
| fl_dq_out | output | DATA_W | Data to flash |
| fl_dq_oe | output | 1 | Data output enable |
| fl_dq_in | input | DATA_W | Data from flash |
| fl_rb | input | 1 | Ready/busy from flash, low while busy |
| busy_irq | output | 1 | Sticky ready interrupt |
| bad_access | output | 1 | Sticky invalid-offset flag |

## Verification
The hardest case to reach is a software clear that lands in the same clock as a detected ready edge. The clear must lose. The stimulus reaches it by raising the ready/busy pin and then timing the control write to the third clock edge after the rise, counted through the synchronizer. Hold-mode enable is also checked with the chip-select dropped, so that an enable that wrongly follows the bus would show.

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [2:1]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ctl_wr,
  input  logic [5:0]        ctl_wdata,
  output logic [5:0]        ctl_rdata,
  output logic              fl_ce_n,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic              fl_we_n,
  output logic              fl_re_n,
  output logic              fl_wp_n,
  output logic [DATA_W-1:0] fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_in,
  input  logic              fl_rb,
  output logic              busy_irq,
  output logic              bad_access
);
  localparam int HALF = DATA_W / 2;

  logic hold_mode, sw_en, wp_on, wide;
  logic rb_s1, rb_s2, rb_prev;
  logic irq_q, err_q;

  logic invalid, wr_ok, rd_ok, rb_rise;
  logic [DATA_W-1:0] lane_mask;

  assign invalid = bus_addr == 2'b11;
  assign wr_ok   = bus_cs & bus_wr & ~invalid;
  assign rd_ok   = bus_cs & bus_rd & (bus_addr == 2'b00);
  assign rb_rise = rb_s2 & ~rb_prev;

  assign lane_mask = wide ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};

  assign fl_cle    = bus_cs & (bus_addr == 2'b01);
  assign fl_ale    = bus_cs & (bus_addr == 2'b10);
  assign fl_we_n   = ~wr_ok;
  assign fl_dq_oe  = wr_ok;
  assign fl_re_n   = ~rd_ok;
  assign fl_ce_n   = hold_mode ? ~sw_en : ~bus_cs;
  assign fl_wp_n   = ~wp_on;
  assign fl_dq_out = bus_wdata & lane_mask;
  assign bus_rdata = rd_ok ? (fl_dq_in & lane_mask) : '0;

  assign ctl_rdata  = {err_q, irq_q, wide, wp_on, sw_en, hold_mode};
  assign busy_irq   = irq_q;
  assign bad_access = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_mode <= 1'b0;
      sw_en     <= 1'b0;
      wp_on     <= 1'b0;
      wide      <= 1'b0;
    end else if (ctl_wr) begin
      hold_mode <= ctl_wdata[0];
      sw_en     <= ctl_wdata[1];
      wp_on     <= ctl_wdata[2];
      wide      <= ctl_wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_s1   <= 1'b1;
      rb_s2   <= 1'b1;
      rb_prev <= 1'b1;
    end else begin
      rb_s1   <= fl_rb;
      rb_s2   <= rb_s1;
      rb_prev <= rb_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (rb_rise)
        irq_q <= 1'b1;
      else if (ctl_wr && ctl_wdata[4])
        irq_q <= 1'b0;
      if (bus_cs && (bus_rd || bus_wr) && invalid)
        err_q <= 1'b1;
      else if (ctl_wr && ctl_wdata[5])
        err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nand_bus_bridge_chk.sv
module nand_bus_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_cs,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [2:1] bus_addr,
  input logic       ctl_wr,
  input logic [5:0] ctl_wdata,
  input logic       fl_we_n,
  input logic       fl_re_n,
  input logic       fl_cle,
  input logic       fl_ale,
  input logic       busy_irq,
  input logic       bad_access
);
  p_no_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs |-> (fl_we_n && fl_re_n && !fl_cle && !fl_ale));

  p_no_we_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'b11) |-> fl_we_n);

  p_re_data_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_re_n |-> (!fl_cle && !fl_ale));

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_irq && !(ctl_wr && ctl_wdata[4])) |=> busy_irq);

  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && (bus_rd || bus_wr) && bus_addr == 2'b11) |=> bad_access);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_access && !(ctl_wr && ctl_wdata[5])) |=> bad_access);
endmodule

bind nand_bus_bridge nand_bus_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
  .busy_irq(busy_irq), .bad_access(bad_access)
);

// File: tb/nand_bus_bridge_test.sv
`timescale 1ns/1ps
module nand_bus_bridge_test;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic bus_cs = 0, bus_rd = 0, bus_wr = 0;
  logic [2:1] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, fl_dq_in = 0;
  logic ctl_wr = 0;
  logic [5:0] ctl_wdata = 0;
  logic fl_rb = 1;
  logic [DW-1:0] bus_rdata, fl_dq_out;
  logic [5:0] ctl_rdata;
  logic fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_wp_n, fl_dq_oe, busy_irq, bad_access;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nand_bus_bridge #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n),
    .fl_re_n(fl_re_n), .fl_wp_n(fl_wp_n), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_rb(fl_rb), .busy_irq(busy_irq), .bad_access(bad_access)
  );

  int m_ctl, m_irq, m_err;
  int rbq[$] = '{1, 1, 1};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_irq = 0; m_err = 0;
      rbq = '{1, 1, 1};
    end else begin
      if (ctl_wr && ctl_wdata[4]) m_irq = 0;
      if (rbq[1] == 1 && rbq[2] == 0) m_irq = 1;
      if (ctl_wr && ctl_wdata[5]) m_err = 0;
      if (bus_cs && (bus_rd || bus_wr) && bus_addr == 2'b11) m_err = 1;
      if (ctl_wr) m_ctl = ctl_wdata[3:0];
      rbq.push_front(int'(fl_rb));
      void'(rbq.pop_back());
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int sel, mask, ecle, eale, ewe, ere;
      sel  = bus_cs ? {30'd0, bus_addr} : -1;
      mask = m_ctl[3] ? 16'hFFFF : 16'h00FF;
      ecle = (sel == 1);
      eale = (sel == 2);
      ewe  = !(bus_cs && bus_wr && sel != 3);
      ere  = !(bus_cs && bus_rd && sel == 0);
      check("R1", "cle", fl_cle, ecle);
      check("R1", "ale", fl_ale, eale);
      check("R2", "we_n", fl_we_n, ewe);
      check("R2", "dq_oe", fl_dq_oe, !ewe);
      check("R3", "re_n", fl_re_n, ere);
      check("R3", "rdata", bus_rdata, ere ? 0 : (fl_dq_in & mask));
      check("R4", "ce_n", fl_ce_n, m_ctl[0] ? !m_ctl[1] : !bus_cs);
      check("R5", "wp_n", fl_wp_n, !m_ctl[2]);
      check("R6", "dq_out", fl_dq_out, bus_wdata & mask);
      check("R7", "irq", busy_irq, m_irq);
      check("R9", "err", bad_access, m_err);
      check("R10", "ctl_rdata", ctl_rdata, (m_err << 5) | (m_irq << 4) | m_ctl);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic bus_op(bit wr, logic [2:1] a, logic [DW-1:0] wd, logic [DW-1:0] din);
    bus_cs = 1; bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = wd; fl_dq_in = din;
    idle(1);
    bus_cs = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0;
  endtask

  task automatic ctl_write(logic [5:0] v);
    ctl_wr = 1; ctl_wdata = v;
    idle(1);
    ctl_wr = 0; ctl_wdata = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    check("R10", "reset ctl", ctl_rdata, 0);
    check("R10", "reset we_n", fl_we_n, 1);
    // R1 R2 R6: command, address, narrow data write
    bus_op(1, 2'b01, 16'h0090, 0);
    bus_op(1, 2'b10, 16'h0000, 0);
    bus_cs = 1; bus_wr = 1; bus_addr = 2'b00; bus_wdata = 16'hABCD;
    idle(1);
    check("R6", "narrow dq_out", fl_dq_out, 16'h00CD);
    bus_cs = 0; bus_wr = 0;
    // R6 wide lane
    ctl_write(6'h08);
    bus_op(1, 2'b00, 16'hABCD, 0);
    bus_cs = 1; bus_rd = 1; bus_addr = 2'b00; fl_dq_in = 16'h1234;
    idle(1);
    check("R3", "wide read", bus_rdata, 16'h1234);
    bus_cs = 0; bus_rd = 0;
    // R3 reads at non-data offsets
    bus_cs = 1; bus_rd = 1; bus_addr = 2'b01; fl_dq_in = 16'hFFFF;
    idle(1);
    check("R3", "cmd read rdata", bus_rdata, 0);
    check("R3", "cmd read re_n", fl_re_n, 1);
    bus_addr = 2'b10;
    idle(1);
    check("R3", "addr read rdata", bus_rdata, 0);
    bus_cs = 0; bus_rd = 0;
    // R9 invalid offset read then write
    bus_op(0, 2'b11, 0, 16'h5555);
    check("R9", "err after bad read", bad_access, 1);
    ctl_write(6'h28);
    check("R9", "err cleared", bad_access, 0);
    bus_cs = 1; bus_wr = 1; bus_addr = 2'b11;
    idle(1);
    check("R2", "no we on offset 6", fl_we_n, 1);
    bus_cs = 0; bus_wr = 0;
    idle(1);
    check("R9", "err after bad write", bad_access, 1);
    // R6 narrow read
    ctl_write(6'h20);
    bus_cs = 1; bus_rd = 1; bus_addr = 2'b00; fl_dq_in = 16'hBEEF;
    idle(1);
    check("R6", "narrow read", bus_rdata, 16'h00EF);
    bus_cs = 0; bus_rd = 0;
    // R4 hold mode
    ctl_write(6'h0B);
    check("R4", "hold enable cs low", fl_ce_n, 0);
    bus_op(1, 2'b01, 16'h0030, 0);
    ctl_write(6'h09);
    bus_cs = 1;
    idle(1);
    check("R4", "hold released cs high", fl_ce_n, 1);
    bus_cs = 0;
    // R5 write protect
    ctl_write(6'h04);
    check("R5", "wp asserted", fl_wp_n, 0);
    ctl_write(6'h00);
    check("R5", "wp released", fl_wp_n, 1);
    // R7 busy then ready
    fl_rb = 0;
    idle(4);
    check("R7", "falling no irq", busy_irq, 0);
    fl_rb = 1;
    idle(2);
    check("R7", "irq not yet", busy_irq, 0);
    idle(1);
    check("R7", "irq set", busy_irq, 1);
    idle(5);
    check("R7", "irq sticky", busy_irq, 1);
    ctl_write(6'h10);
    check("R8", "irq cleared", busy_irq, 0);
    // R8 clear collides with detected edge
    fl_rb = 0;
    idle(4);
    fl_rb = 1;
    idle(2);
    ctl_write(6'h10);
    check("R8", "set wins over clear", busy_irq, 1);
    ctl_write(6'h10);
    check("R8", "cleared after", busy_irq, 0);
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule